// File: doc/BRIEF.md
# Selectable Reset Source Generator

This block merges three internal reset requests into a single active-low reset output. The requests are a command/indication code change, a subscriber-awake event and a watchdog expiry. A two-bit select field sits in the low bits of a mode register and decides which requests may start an output pulse. One select encoding is reserved, and with it no pulse is ever produced. The pulse width is measured in frame ticks, which arrive every 125 µs. A pulse ends on the second tick after it starts, so it always lasts between one and two frame periods.

Any of the three internal events returns the mode register to its reset value. This also resets the select field. A software reset register has one bit for each register group. Writing a set bit gives a one-cycle clear strobe for that group, and the register then clears itself. The external reset input brings every register in the block back to its initial state.

Top module: `rst_src_sel`

## Requirements
- R1: With select (mode bits [1:0]) = 00, a code-change or subscriber-awake event starts a pulse, and a watchdog event does not.
- R2: With select = 10 or 11, only a watchdog event starts a pulse. Code-change and subscriber-awake events do not.
- R3: With select = 01, no event starts a pulse, and `rst_out_n` stays high.
- R4: An accepted event drives `rst_out_n` low from the next clock edge. The output returns high at the edge that samples the second `frame_tick` after the pulse started. A tick in the same cycle as the event is not counted.
- R5: While a pulse is active, further events neither restart it nor lengthen it.
- R6: Any of the three events sets `mode_q` to `MODE_RST` (default 00h) at the next edge, whatever the select value. An event wins over a mode write in the same cycle. `mode_clr` is high for the cycle after each event cycle.
- R7: A write to the software reset register drives `grp_clr` to the written bits [5:0] for exactly one cycle, then `grp_clr` returns to zero. The bit mapping is: 0 = D/C-I channel, 1 = transceiver, 2 = IOM-2, 3 = monitor channel, 4 = general configuration, 5 = B-channels.
- R8: While `rst_n` is low, `rst_out_n` is 1, `mode_q` is `MODE_RST`, and `grp_clr` and `mode_clr` are 0.
- R9: When no event is present, a mode write loads `wr_data` into `mode_q` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| frame_tick | input | 1 | One-cycle strobe every frame period (125 µs) |
| ev_code_chg | input | 1 | Command/indication code change event |
| ev_sub_awake | input | 1 | Subscriber-awake event |
| ev_wdog | input | 1 | Watchdog expiry event |
| wr_mode | input | 1 | Write strobe for the mode register |
| wr_sres | input | 1 | Write strobe for the software reset register |
| wr_data | input | DATA_W | Write data |
| rst_out_n | output | 1 | Active-low reset pulse output |
| mode_q | output | DATA_W | Mode register contents; bits [1:0] are the select |
| mode_clr | output | 1 | One-cycle strobe after an internal event clears the mode register |
| grp_clr | output | GRP_N | One-cycle per-group clear strobes |

## Verification
A stuck or wrong pulse flag shows on `rst_out_n` in the cycle after the event that should or should not have started a pulse. A wrong tick count shows up to one frame period later, as a release edge that arrives early or late. A mode register that was not cleared shows on `mode_q` one cycle after the event. It also shows later, when a following event is accepted or refused under the wrong select. Software reset bits that do not clear themselves appear on `grp_clr` as a strobe held for two cycles.

// File: rtl/rst_src_sel.sv
module rst_src_sel #(
  parameter int          DATA_W   = 8,
  parameter int          GRP_N    = 6,
  parameter int          TICKS    = 2,
  parameter logic [7:0]  MODE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              ev_code_chg,
  input  logic              ev_sub_awake,
  input  logic              ev_wdog,
  input  logic              wr_mode,
  input  logic              wr_sres,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_out_n,
  output logic [DATA_W-1:0] mode_q,
  output logic              mode_clr,
  output logic [GRP_N-1:0]  grp_clr
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [DATA_W-1:0] MRST = DATA_W'(MODE_RST);

  logic          pulse_q;
  logic [CW-1:0] tick_cnt;
  logic [1:0]    sel;
  logic          any_ev, take;

  assign sel    = mode_q[1:0];
  assign any_ev = ev_code_chg | ev_sub_awake | ev_wdog;
  assign take   = !pulse_q && (((sel == 2'b00) && (ev_code_chg || ev_sub_awake)) ||
                               (sel[1] && ev_wdog));
  assign rst_out_n = !pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      tick_cnt <= '0;
    end else if (pulse_q) begin
      if (frame_tick) begin
        if (tick_cnt == CW'(TICKS - 1)) begin
          pulse_q  <= 1'b0;
          tick_cnt <= '0;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end else if (take) begin
      pulse_q  <= 1'b1;
      tick_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MRST;
      mode_clr <= 1'b0;
      grp_clr  <= '0;
    end else begin
      if (any_ev)       mode_q <= MRST;
      else if (wr_mode) mode_q <= wr_data;
      mode_clr <= any_ev;
      grp_clr  <= wr_sres ? wr_data[GRP_N-1:0] : '0;
    end
  end

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01 && rst_out_n) |=> rst_out_n); // R3
  AST_WDOG_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && sel[1] && ev_wdog) |=> !rst_out_n); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !frame_tick) |=> !rst_out_n); // R4
  AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> (mode_q == MRST && mode_clr)); // R6
  AST_GRP_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sres |=> (grp_clr == '0)); // R7
endmodule

// File: tb/rst_src_sel_bench.sv
module rst_src_sel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic ev_cc = 1'b0, ev_aw = 1'b0, ev_wd = 1'b0;
  logic wr_mode = 1'b0, wr_sres = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_out_n, mode_clr;
  logic [7:0] mode_q;
  logic [5:0] grp_clr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_src_sel u_rst_src_sel (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .ev_code_chg(ev_cc), .ev_sub_awake(ev_aw), .ev_wdog(ev_wd),
    .wr_mode(wr_mode), .wr_sres(wr_sres), .wr_data(wr_data),
    .rst_out_n(rst_out_n), .mode_q(mode_q), .mode_clr(mode_clr), .grp_clr(grp_clr)
  );

  // reference model
  bit       m_act = 0;
  int       m_ticks = 0;
  bit [7:0] m_mode = 8'h00;
  bit       m_mclr = 0;
  bit [5:0] m_grp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ticks = 0; m_mode = 8'h00; m_mclr = 0; m_grp = 0;
    end else begin
      bit acc;
      acc = !m_act && ((m_mode[1:0] == 2'b00 && (ev_cc || ev_aw)) || (m_mode[1] && ev_wd));
      if (m_act) begin
        if (frame_tick) begin
          m_ticks++;
          if (m_ticks == 2) begin m_act = 0; m_ticks = 0; end
        end
      end else if (acc) begin
        m_act = 1; m_ticks = 0;
      end
      m_mclr = ev_cc || ev_aw || ev_wd;
      if (m_mclr) m_mode = 8'h00;
      else if (wr_mode) m_mode = wr_data;
      m_grp = wr_sres ? wr_data[5:0] : 6'h0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    cyc++;
    #5;
    chk(rst_out_n == !m_act, "R1/R2/R3/R4/R5 rst_out_n", rst_out_n, !m_act);
    chk(mode_q == m_mode, "R6/R9 mode_q", mode_q, m_mode);
    chk(mode_clr == m_mclr, "R6 mode_clr", mode_clr, m_mclr);
    chk(grp_clr == m_grp, "R7 grp_clr", grp_clr, m_grp);
  end

  // frame ticks every 40 cycles
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 39) ? 0 : tdiv + 1;
    frame_tick <= (tdiv == 0);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic pulse_ev(input int which);
    @(negedge clk);
    ev_cc = (which == 0); ev_aw = (which == 1); ev_wd = (which == 2);
    @(negedge clk);
    ev_cc = 0; ev_aw = 0; ev_wd = 0;
  endtask
  task automatic wmode(input logic [7:0] d);
    @(negedge clk); wr_mode = 1; wr_data = d;
    @(negedge clk); wr_mode = 0;
  endtask
  task automatic wsres(input logic [7:0] d);
    @(negedge clk); wr_sres = 1; wr_data = d;
    @(negedge clk); wr_sres = 0;
  endtask

  initial begin
    #5;
    chk(rst_out_n == 1'b1, "R8 reset rst_out_n", rst_out_n, 1);
    chk(mode_q == 8'h00, "R8 reset mode_q", mode_q, 0);
    chk(grp_clr == 6'h0 && mode_clr == 0, "R8 reset strobes", grp_clr, 0);
    idle(3); rst_n = 1; idle(3);
    pulse_ev(0); idle(100);                 // R1 code change
    pulse_ev(1); idle(100);                 // R1 awake
    pulse_ev(2); idle(50);                  // R1 watchdog ignored, mode cleared R6
    wmode(8'h02); pulse_ev(2); idle(100);   // R2 watchdog accepted
    wmode(8'h03); pulse_ev(0); idle(20);    // R2 code change refused
    wmode(8'hA1); pulse_ev(0); idle(20);    // R3 reserved
    wmode(8'h01); pulse_ev(2); idle(20);    // R3
    pulse_ev(0); idle(30); pulse_ev(1); idle(5); pulse_ev(0); idle(100); // R5
    @(negedge clk); ev_wd = 1; wr_mode = 1; wr_data = 8'h5A;             // R6 priority
    @(negedge clk); ev_wd = 0; wr_mode = 0; idle(5);
    wsres(8'h3F); idle(3); wsres(8'h15); wsres(8'hEA); idle(3);          // R7
    @(negedge clk); ev_aw = 1; @(negedge clk); ev_aw = 0; idle(39);       // R4 tick alignment
    wmode(8'h06); idle(2);                                                // R9
    pulse_ev(0); idle(10);
    @(negedge clk); rst_n = 0; #2;
    chk(rst_out_n == 1'b1 && mode_q == 8'h00, "R8 async reset", {rst_out_n, mode_q}, 9'h100);
    idle(2); rst_n = 1; idle(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule